// File: doc/BRIEF.md
# Fractional-N Main Divider Sequencer

This block runs on the output clock of an external multi-modulus prescaler, which divides by 64, 65 or 72. It counts those output pulses and drives the prescaler's modulus-select lines. Over one main cycle it spends a programmed number of prescaler periods at each modulus, so the RF input is divided by the programmed integer ratio. A small fractional accumulator is advanced at the end of every main cycle. Each time the accumulator wraps, the next main cycle trades one divide-by-64 period for a divide-by-65 period, which lengthens that cycle by one RF period. Over 5 or 8 main cycles this gives a mean ratio of N + NF/Q.

A new ratio word waits at the edge of the block on a request line. The sequencer takes it only at the end of a main cycle, in the cycle that also produces the phase-detector pulse, so a change of ratio never splits a cycle. The controller is a state machine with four states:
- `S_IDLE`: disabled, nothing is counted.
- `S_P64`: counting the divide-by-64 periods.
- `S_P65`: counting the divide-by-65 periods.
- `S_P72`: counting the divide-by-72 periods.

Its transitions are:
- START: `S_IDLE` to `S_P64` when enabled.
- ADVANCE: `S_P64` to `S_P65`, `S_P64` to `S_P72`, or `S_P65` to `S_P72`, when a phase count runs out and a later phase is not empty.
- WRAP: from the last period of any phase back to `S_P64`, which ends the main cycle.
- HALT: from any state to `S_IDLE` when the enable is low.

Top module: `fracn_main_div`

## Requirements
- R1: While reset is held and just after it is released, `frac_acc` is 0, `div_out_n` is 1, `ld_ack` is 0 and `mod_sel` is 2'b00. The working ratio after reset is NM1=NM2=NM3=0 in two-modulus mode.
- R2: `mod_sel` encodes the modulus of the current prescaler period: 2'b00 = /64, 2'b01 = /65, 2'b10 = /72. In two-modulus mode (selector bit 1 = 0), a main cycle without a correction sums to (NM1+2)·64 + NM2·65.
- R3: In three-modulus mode (selector bit 1 = 1), a main cycle sums to (NM1+2)·64 + NM2·65 + (NM3+1)·72. Only the low 4 bits of NM2 are used in this mode.
- R4: Within one main cycle the moduli follow the order /64, then /65, then /72. The order returns to /64 only when a new main cycle starts.
- R5: `div_out_n` is low for exactly one prescaler period, the first period of every main cycle that follows another main cycle. It is high at all other times.
- R6: At each main-cycle boundary, `frac_acc` becomes (frac_acc + NF) mod Q, where Q = 8 if `fmod`=1 and Q = 5 if `fmod`=0. An NF of Q or more counts as NF−Q. `frac_acc` changes at no other time.
- R7: When the boundary addition wraps, the main cycle that follows uses NM1+1 periods of /64 and NM2+1 periods of /65, so its total is one more than the R2 or R3 ratio.
- R8: `ld_ack` is high only in the final prescaler period of a main cycle while `ld_req` is high. The new word takes effect from the next main cycle. A request raised earlier in a cycle waits for that cycle's final period.
- R9: With `en` low the block is idle from the next edge: `div_out_n` is 1, `mod_sel` is /64, `ld_ack` is 0 and `frac_acc` holds its value. After `en` rises, a fresh main cycle with no correction starts at the following edge. That first cycle produces no pulse at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock; one rising edge per prescaler period |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Divider enable |
| ld_req | input | 1 | A new ratio word is pending |
| ld_nm1 | input | 12 | Pending count of /64 periods (minus two) |
| ld_nm2 | input | 8 | Pending count of /65 periods |
| ld_nm3 | input | 4 | Pending count of /72 periods (minus one) |
| ld_pr | input | 2 | Pending prescaler mode; bit 1 selects three-modulus operation |
| nf | input | 3 | Fractional increment |
| fmod | input | 1 | Accumulator modulus: 1 = 8, 0 = 5 |
| mod_sel | output | 2 | Modulus select to the prescaler |
| div_out_n | output | 1 | Active-low divider output pulse to the phase detector |
| frac_acc | output | 3 | Fractional accumulator contents |
| ld_ack | output | 1 | Pending word accepted at this boundary |

## Verification
The bench adds up the selected moduli between consecutive output pulses and compares the sum with the expected ratio. A design that drops or duplicates a phase period, or that puts the correction in the wrong cycle, gives a sum that is off by 64, 65, 72 or 1. The corners it targets are:
- The shortest cycle, NM1=0 and NM2=0, where the corrected /64 phase holds a single period.
- An NF above 4 with modulus 5, which a design without the wrap reduction would push past the modulus.
- An NM2 with high bits set in three-modulus mode, which a design that does not mask them would over-count.
- A request raised at the very start of a cycle. The bench counts the periods until the acknowledge, so an early acceptance shows up as too few periods.
- Disabling in mid-cycle and re-enabling. A leftover correction or a moving accumulator would show up in the next sums.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    typedef enum logic [1:0] {
        MOD64 = 2'b00,
        MOD65 = 2'b01,
        MOD72 = 2'b10
    } mod_sel_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_P64,
        S_P65,
        S_P72
    } phase_e;

endpackage

// File: rtl/fracn_frac_acc.sv
module fracn_frac_acc #(
    parameter int NF_W = 3,
    parameter int Q_HI = 8,
    parameter int Q_LO = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [NF_W-1:0] nf,
    input  logic            fmod,
    output logic [NF_W-1:0] acc,
    output logic            wrap
);
    localparam int SW = NF_W + 1;

    logic [SW-1:0] q;
    logic [SW-1:0] inc;
    logic [SW-1:0] sum;
    logic [SW-1:0] nxt;

    always_comb begin
        q    = fmod ? SW'(Q_HI) : SW'(Q_LO);
        inc  = ({1'b0, nf} >= q) ? ({1'b0, nf} - q) : {1'b0, nf};
        sum  = {1'b0, acc} + inc;
        wrap = (sum >= q);
        nxt  = wrap ? (sum - q) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (step)
            acc <= nxt[NF_W-1:0];
    end

endmodule

// File: rtl/fracn_phase_fsm.sv
module fracn_phase_fsm
    import fracn_pkg::*;
#(
    parameter int NM1_W     = 12,
    parameter int NM2_W     = 8,
    parameter int NM2_TRI_W = 4,
    parameter int NM3_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [NM1_W-1:0] nm1_i,
    input  logic [NM2_W-1:0] nm2_i,
    input  logic [NM3_W-1:0] nm3_i,
    input  logic             tri_i,
    input  logic             wrap_i,
    output logic [1:0]       mod_sel,
    output logic             final_cyc,
    output logic             div_n
);
    localparam int CW  = NM1_W + 1;
    localparam int L2W = NM2_W + 1;
    localparam logic [NM2_W-1:0] TRI_MASK = NM2_W'((1 << NM2_TRI_W) - 1);

    phase_e            st;
    logic [CW-1:0]     cnt;
    logic [L2W-1:0]    len65;
    logic [NM3_W-1:0]  len72;
    logic              tri_r;

    logic              start;
    logic              corr;
    logic [NM2_W-1:0]  nm2_eff;
    logic [CW-1:0]     c64_ld;
    logic [L2W-1:0]    l65_ld;

    always_comb begin
        final_cyc = (cnt == '0) &&
                    ((st == S_P64 && len65 == '0 && !tri_r) ||
                     (st == S_P65 && !tri_r) ||
                     (st == S_P72));
        start   = en && ((st == S_IDLE) || final_cyc);
        corr    = (st == S_IDLE) ? 1'b0 : wrap_i;
        nm2_eff = tri_i ? (nm2_i & TRI_MASK) : nm2_i;
        c64_ld  = CW'(nm1_i) + CW'(1) - CW'(corr);
        l65_ld  = L2W'(nm2_eff) + L2W'(corr);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= '0;
            len65 <= '0;
            len72 <= '0;
            tri_r <= 1'b0;
            div_n <= 1'b1;
        end else if (!en) begin
            st    <= S_IDLE;
            cnt   <= '0;
            div_n <= 1'b1;
        end else if (start) begin
            st    <= S_P64;
            cnt   <= c64_ld;
            len65 <= l65_ld;
            len72 <= nm3_i;
            tri_r <= tri_i;
            div_n <= (st == S_IDLE);
        end else begin
            div_n <= 1'b1;
            if (cnt != '0) begin
                cnt <= cnt - CW'(1);
            end else begin
                unique case (st)
                    S_P64: begin
                        if (len65 != '0) begin
                            st  <= S_P65;
                            cnt <= CW'(len65 - L2W'(1));
                        end else begin
                            st  <= S_P72;
                            cnt <= CW'(len72);
                        end
                    end
                    S_P65: begin
                        st  <= S_P72;
                        cnt <= CW'(len72);
                    end
                    default: begin
                        st <= st;
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            S_P65:   mod_sel = MOD65;
            S_P72:   mod_sel = MOD72;
            default: mod_sel = MOD64;
        endcase
    end

    // R4: a return to the /64 phase from a later phase only opens a new main cycle
    p_phase_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_P64 && ($past(st) == S_P65 || $past(st) == S_P72)) |-> !div_n);

    // R4: the /72 phase is reached only in three-modulus cycles
    p_tri_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_P72) |-> tri_r);

endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
    import fracn_pkg::*;
#(
    parameter int NM1_W     = 12,
    parameter int NM2_W     = 8,
    parameter int NM2_TRI_W = 4,
    parameter int NM3_W     = 4,
    parameter int NF_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ld_req,
    input  logic [NM1_W-1:0] ld_nm1,
    input  logic [NM2_W-1:0] ld_nm2,
    input  logic [NM3_W-1:0] ld_nm3,
    input  logic [1:0]       ld_pr,
    input  logic [NF_W-1:0]  nf,
    input  logic             fmod,
    output logic [1:0]       mod_sel,
    output logic             div_out_n,
    output logic [NF_W-1:0]  frac_acc,
    output logic             ld_ack
);
    logic [NM1_W-1:0] w_nm1;
    logic [NM2_W-1:0] w_nm2;
    logic [NM3_W-1:0] w_nm3;
    logic             w_tri;

    logic [NM1_W-1:0] u_nm1;
    logic [NM2_W-1:0] u_nm2;
    logic [NM3_W-1:0] u_nm3;
    logic             u_tri;

    logic final_cyc;
    logic wrap;

    assign ld_ack = en && final_cyc && ld_req;

    always_comb begin
        u_nm1 = ld_ack ? ld_nm1   : w_nm1;
        u_nm2 = ld_ack ? ld_nm2   : w_nm2;
        u_nm3 = ld_ack ? ld_nm3   : w_nm3;
        u_tri = ld_ack ? ld_pr[1] : w_tri;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_nm1 <= '0;
            w_nm2 <= '0;
            w_nm3 <= '0;
            w_tri <= 1'b0;
        end else if (ld_ack) begin
            w_nm1 <= ld_nm1;
            w_nm2 <= ld_nm2;
            w_nm3 <= ld_nm3;
            w_tri <= ld_pr[1];
        end
    end

    fracn_phase_fsm #(
        .NM1_W     (NM1_W),
        .NM2_W     (NM2_W),
        .NM2_TRI_W (NM2_TRI_W),
        .NM3_W     (NM3_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .nm1_i     (u_nm1),
        .nm2_i     (u_nm2),
        .nm3_i     (u_nm3),
        .tri_i     (u_tri),
        .wrap_i    (wrap),
        .mod_sel   (mod_sel),
        .final_cyc (final_cyc),
        .div_n     (div_out_n)
    );

    fracn_frac_acc #(
        .NF_W (NF_W)
    ) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (en && final_cyc),
        .nf    (nf),
        .fmod  (fmod),
        .acc   (frac_acc),
        .wrap  (wrap)
    );

    // R6: the accumulator moves only at a main-cycle boundary
    p_acc_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frac_acc) |-> !div_out_n);

    // R8: an accepted word is followed by the start of a new main cycle
    p_ack_then_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ack |=> !div_out_n);

    // R5: the output pulse lasts one prescaler period
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !div_out_n |=> div_out_n);

    // R9: disabling silences the outputs from the next edge
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (div_out_n && !ld_ack && mod_sel == MOD64));

endmodule

// File: tb/fracn_main_div_tb.sv
module fracn_main_div_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        ld_req = 1'b0;
    logic [11:0] ld_nm1 = '0;
    logic [7:0]  ld_nm2 = '0;
    logic [3:0]  ld_nm3 = '0;
    logic [1:0]  ld_pr = 2'b01;
    logic [2:0]  nf = '0;
    logic        fmod = 1'b0;
    logic [1:0]  mod_sel;
    logic        div_out_n;
    logic [2:0]  frac_acc;
    logic        ld_ack;

    always #4 clk = ~clk;

    fracn_main_div dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .ld_req(ld_req),
        .ld_nm1(ld_nm1), .ld_nm2(ld_nm2), .ld_nm3(ld_nm3), .ld_pr(ld_pr),
        .nf(nf), .fmod(fmod), .mod_sel(mod_sel), .div_out_n(div_out_n),
        .frac_acc(frac_acc), .ld_ack(ld_ack)
    );

    int compared = 0;
    int mismatched = 0;
    int qn[$];
    int qa[$];
    int m_acc = 0;
    int m_wrap = 0;
    event drained;

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int weight(input logic [1:0] m);
        case (m)
            2'b00:   return 64;
            2'b01:   return 65;
            2'b10:   return 72;
            default: return 0;
        endcase
    endfunction

    function automatic int ratio(input int a, input int b, input int c, input int pr, input int w);
        int n2;
        n2 = pr[1] ? (b & 15) : b;
        return (a + 2 - w) * 64 + (n2 + w) * 65 + (pr[1] ? (c + 1) * 72 : 0);
    endfunction

    function automatic int periods(input int a, input int b, input int c, input int pr);
        int n2;
        n2 = pr[1] ? (b & 15) : b;
        return a + 2 + n2 + (pr[1] ? c + 1 : 0);
    endfunction

    // accumulator model for one boundary (R6, R7)
    task automatic model_step();
        int q;
        int e;
        int s;
        q = fmod ? 8 : 5;
        e = (int'(nf) >= q) ? int'(nf) - q : int'(nf);
        s = m_acc + e;
        m_wrap = (s >= q) ? 1 : 0;
        m_acc = m_wrap ? s - q : s;
    endtask

    task automatic push_cycles(input int k, input int a, input int b, input int c, input int pr);
        for (int i = 0; i < k; i++) begin
            model_step();
            qn.push_back(ratio(a, b, c, pr, m_wrap));
            qa.push_back(m_acc);
        end
    endtask

    // monitor / scoreboard
    int  sum = 0;
    bit  have_prev = 0;
    bit  prev_low = 0;
    always @(negedge clk) begin
        if (!rst_n || !en) begin
            have_prev = 0;
            prev_low = 0;
            sum = 0;
        end else begin
            if (prev_low)
                chk("R5 pulse width", int'(div_out_n), 1);
            prev_low = !div_out_n;
            if (!div_out_n) begin
                if (have_prev && qn.size() > 0) begin
                    chk("R2/R3/R7 cycle ratio", sum, qn.pop_front());
                    void'(qa.pop_front());
                    if (qn.size() == 0) -> drained;
                end
                if (qa.size() > 0)
                    chk("R6 accumulator", int'(frac_acc), qa[0]);
                have_prev = 1;
                sum = 0;
            end
            if (have_prev)
                sum += weight(mod_sel);
        end
    end

    task automatic do_reset(input int nfv, input bit fm);
        rst_n = 1'b0;
        en = 1'b0;
        ld_req = 1'b0;
        nf = 3'(nfv);
        fmod = fm;
        qn.delete();
        qa.delete();
        m_acc = 0;
        m_wrap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_word(input int a, input int b, input int c, input int pr);
        ld_nm1 = 12'(a);
        ld_nm2 = 8'(b);
        ld_nm3 = 4'(c);
        ld_pr = 2'(pr);
    endtask

    task automatic wait_ack_release();
        int guard;
        guard = 0;
        while (!ld_ack && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        #1 ld_req = 1'b0;
    endtask

    task automatic run_fresh(input int k, input int a, input int b, input int c, input int pr);
        set_word(a, b, c, pr);
        ld_req = 1'b1;
        en = 1'b1;
        push_cycles(k, a, b, c, pr);
        wait_ack_release();
        @(drained);
    endtask

    initial begin
        int cnt;

        // reset state (R1)
        do_reset(0, 1'b1);
        chk("R1 frac_acc", int'(frac_acc), 0);
        chk("R1 div_out_n", int'(div_out_n), 1);
        chk("R1 ld_ack", int'(ld_ack), 0);
        chk("R1 mod_sel", int'(mod_sel), 0);

        // R2: two-modulus, no fraction
        run_fresh(3, 3, 2, 0, 1);

        // R6 R7: modulo 8, wraps
        do_reset(3, 1'b1);
        run_fresh(9, 10, 0, 0, 1);

        // R3: three-modulus, NM2 high bits ignored, modulo 5
        do_reset(2, 1'b0);
        run_fresh(6, 2, 8'h35, 3, 2);

        // R6: NF above modulus 5, shortest cycle
        do_reset(7, 1'b0);
        run_fresh(6, 0, 0, 0, 1);

        // R8: request raised at the start of a cycle waits for its final period
        model_step();
        qn.push_back(ratio(0, 0, 0, 1, m_wrap));
        qa.push_back(m_acc);
        set_word(1, 2, 0, 2);
        ld_req = 1'b1;
        push_cycles(3, 1, 2, 0, 2);
        cnt = 0;
        while (!ld_ack && cnt < 20000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R8 periods until ack", cnt, periods(0, 0, 0, 1) - 1);
        @(posedge clk);
        #1 ld_req = 1'b0;
        @(negedge clk);
        chk("R8 pulse after ack", int'(div_out_n), 0);
        @(drained);

        // R9: disable in mid-stream, request ignored while idle
        model_step();
        en = 1'b0;
        set_word(5, 9, 0, 1);
        ld_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 idle div_out_n", int'(div_out_n), 1);
            chk("R9 idle ld_ack", int'(ld_ack), 0);
            chk("R9 idle mod_sel", int'(mod_sel), 0);
            chk("R9 idle frac_acc", int'(frac_acc), m_acc);
        end
        en = 1'b1;
        push_cycles(3, 5, 9, 0, 1);
        wait_ack_release();
        @(drained);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("R2 watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule